// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the device-side front end of a byte-wide flash command port. A host writes bytes on an 8-bit bus, one per write strobe. A select line marks each byte as a command (select low) or as an address byte (select high). The sequencer follows the multi-byte setup sequences for serial read, identifier read, sector erase, four kinds of sector program, data recovery read and write, reset and status clear. When a sequence is complete it sends a one-cycle start pulse, with the operation kind and the latched sector and column, to the internal operation engine. It also drives a ready/busy output that pulls low while the engine works.

A down-counter stands in for the engine's run time. Program, erase and recovery-write operations take one fixed duration, and the first access of a serial read takes a shorter one. While busy is asserted, the bus is closed to every byte, including reset, and chip enable has no effect. The engine reports failure on a plain input when an operation finishes, which sets a sticky error flag. The recovery write path checks this flag's partner state: the most significant sector bit of the last programmed sector.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `rb_low`, `op_start` and `stat_err` are 0 and `mode` is 0. Mode codes: 0 standby, 1 setup in progress, 2 serial read data, 3 identifier read, 4 recovery read.
- R2: A byte is taken only at a clock edge where `wr_stb` is 1 and `ce_n` is 0. With `cmd_sel` 0 it is a command; with `cmd_sel` 1 it is an address byte. An address byte in standby leaves the mode at 0.
- R3: Command 00H or F0H, then two address bytes, starts a serial read. The sector is the first byte for bits 7:0 and `din[5:0]` of the second byte for bits 13:8; `din[7:6]` is ignored. `op_kind` is 0 with column 000H for 00H, and 1 with column 800H for F0H. Mode becomes 2, and `rb_low` is high for exactly ACC_CYCLES cycles starting the cycle after the second address byte.
- R4: In read-data mode, and in the load phase of programs 10H and 11H, address bytes form column pairs. The low byte comes first, then a byte whose `din[3:0]` gives bits 11:8. The last pair wins. A pair above 83FH is discarded and the previous column is kept.
- R5: Command 20H, two sector bytes, then command B0H starts an erase (`op_kind` 2, column 000H). `rb_low` is high for exactly OP_CYCLES cycles starting the cycle after B0H.
- R6: Program setups 10H, 11H, 1FH and 0FH (`op_kind` 3, 4, 5, 6) take two sector bytes and start on command 40H. Program 0FH uses column 800H; the others use 000H unless a column pair is loaded. An address byte in the load phase of 1FH or 0FH returns the block to standby with no start.
- R7: While `rb_low` is 1, every byte (including FFH) and `ce_n` are ignored. Each start pulse coincides with `rb_low` high.
- R8: A command byte other than the expected confirm, received in any setup state, returns the block to standby with no start.
- R9: `ce_n` high while not busy returns the block to standby (mode 0).
- R10: Command 12H, two sector bytes, then command 40H starts a recovery write (`op_kind` 7). It does so only if sector bit 13 equals bit 13 of the sector of the last started program. Otherwise the block returns to standby with no start.
- R11: `stat_err` is set when a program, erase or recovery write finishes with `op_fail` high. Commands 50H and FFH clear it and return the block to standby. Command 90H enters mode 3 and command 01H enters mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ce_n | input | 1 | chip enable, active low |
| cmd_sel | input | 1 | 0 marks a command byte, 1 an address byte |
| wr_stb | input | 1 | one-cycle write strobe |
| din | input | 8 | byte bus |
| op_fail | input | 1 | engine failure report, sampled at operation end |
| rb_low | output | 1 | 1 pulls ready/busy low (busy) |
| op_start | output | 1 | one-cycle start pulse to the engine |
| op_kind | output | 3 | operation kind (codes in R3, R5, R6, R10) |
| op_sector | output | 14 | latched sector address |
| op_column | output | 12 | latched column address |
| mode | output | 3 | current mode code (R1) |
| stat_err | output | 1 | sticky operation error flag |

## Verification
The hardest case to reach is the lockout window. Bytes and chip-enable changes must arrive while an operation is still running, and their absence of effect must then be seen only through later port state. The stimulus first forces a failing program, so `stat_err` is set. It then starts a second operation, and while that runs it sends FFH and 50H, checking after completion that the flag survived. During a read's first access it sends FFH and pulses `ce_n`, then confirms that read mode persists. The recovery write bit-13 rule depends on earlier history, so a program to an upper-half sector is run before both a matching and a mismatching recovery write.

// File: rtl/flash_cmd_seq_pkg.sv
package flash_cmd_seq_pkg;

  typedef enum logic [2:0] {
    K_READ_MAIN = 3'd0,
    K_READ_CTRL = 3'd1,
    K_ERASE     = 3'd2,
    K_PROG_ADD  = 3'd3,
    K_PROG_REW  = 3'd4,
    K_PROG_FULL = 3'd5,
    K_PROG_CTRL = 3'd6,
    K_RECOV_WR  = 3'd7
  } op_kind_e;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_SETUP   = 3'd1,
    M_READ    = 3'd2,
    M_ID      = 3'd3,
    M_RECOV   = 3'd4
  } mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RSA1, S_RSA2, S_RDATA, S_ID, S_RCVRD,
    S_ESA1, S_ESA2, S_ECONF, S_PSA1, S_PSA2, S_PLOAD,
    S_WSA1, S_WSA2, S_WCONF
  } seq_state_e;

  localparam logic [7:0] C_READ_MAIN = 8'h00;
  localparam logic [7:0] C_READ_CTRL = 8'hF0;
  localparam logic [7:0] C_ID        = 8'h90;
  localparam logic [7:0] C_ERASE     = 8'h20;
  localparam logic [7:0] C_ERASE_GO  = 8'hB0;
  localparam logic [7:0] C_PROG_ADD  = 8'h10;
  localparam logic [7:0] C_PROG_REW  = 8'h11;
  localparam logic [7:0] C_PROG_FULL = 8'h1F;
  localparam logic [7:0] C_PROG_CTRL = 8'h0F;
  localparam logic [7:0] C_PROG_GO   = 8'h40;
  localparam logic [7:0] C_RESET     = 8'hFF;
  localparam logic [7:0] C_CLEAR     = 8'h50;
  localparam logic [7:0] C_RECOV_RD  = 8'h01;
  localparam logic [7:0] C_RECOV_WR  = 8'h12;

endpackage

// File: rtl/flash_cmd_seq_fsm.sv
module flash_cmd_seq_fsm
  import flash_cmd_seq_pkg::*;
#(
  parameter int unsigned SA_W = 14,
  parameter int unsigned CA_W = 12,
  parameter logic [CA_W-1:0] CA_MAX   = 12'h83F,
  parameter logic [CA_W-1:0] CTRL_COL = 12'h800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            cmd_sel,
  input  logic            wr_stb,
  input  logic [7:0]      din,
  input  logic            busy,
  output logic            launch,
  output logic            launch_read,
  output logic            clr_err,
  output op_kind_e        kind_o,
  output logic [SA_W-1:0] sector_o,
  output logic [CA_W-1:0] column_o,
  output mode_e           mode_o
);

  localparam int unsigned SA_HI = SA_W - 8;
  localparam int unsigned CA_HI = CA_W - 8;

  seq_state_e      st_q, st_n;
  op_kind_e        kind_q, kind_n;
  logic [SA_W-1:0] sec_q, sec_n;
  logic [CA_W-1:0] col_q, col_n;
  logic [7:0]      calo_q, calo_n;
  logic            caph_q, caph_n;
  logic            f13_q, f13_n;
  logic            take, is_cmd, ca_go;
  logic [CA_W-1:0] ca_cand;

  assign take    = wr_stb && !ce_n && !busy;
  assign is_cmd  = !cmd_sel;
  assign ca_cand = {din[CA_HI-1:0], calo_q};

  always_comb begin
    st_n = st_q; kind_n = kind_q; sec_n = sec_q; col_n = col_q;
    calo_n = calo_q; caph_n = caph_q; f13_n = f13_q;
    launch = 1'b0; clr_err = 1'b0; ca_go = 1'b0;
    if (!busy && ce_n) begin
      st_n = S_IDLE; caph_n = 1'b0;
    end else if (take) begin
      if (is_cmd && din == C_RESET) begin
        st_n = S_IDLE; clr_err = 1'b1; caph_n = 1'b0;
      end else begin
        case (st_q)
          S_IDLE, S_RDATA, S_ID, S_RCVRD: begin
            if (is_cmd) begin
              caph_n = 1'b0; col_n = '0; st_n = S_IDLE;
              case (din)
                C_READ_MAIN: begin st_n = S_RSA1; kind_n = K_READ_MAIN; end
                C_READ_CTRL: begin st_n = S_RSA1; kind_n = K_READ_CTRL; col_n = CTRL_COL; end
                C_ID:        st_n = S_ID;
                C_RECOV_RD:  st_n = S_RCVRD;
                C_ERASE:     begin st_n = S_ESA1; kind_n = K_ERASE; end
                C_PROG_ADD:  begin st_n = S_PSA1; kind_n = K_PROG_ADD; end
                C_PROG_REW:  begin st_n = S_PSA1; kind_n = K_PROG_REW; end
                C_PROG_FULL: begin st_n = S_PSA1; kind_n = K_PROG_FULL; end
                C_PROG_CTRL: begin st_n = S_PSA1; kind_n = K_PROG_CTRL; col_n = CTRL_COL; end
                C_RECOV_WR:  begin st_n = S_WSA1; kind_n = K_RECOV_WR; end
                C_CLEAR:     clr_err = 1'b1;
                default:     col_n = col_q;
              endcase
            end else if (st_q == S_RDATA) begin
              ca_go = 1'b1;
            end else begin
              st_n = S_IDLE;
            end
          end
          S_RSA1, S_ESA1, S_PSA1, S_WSA1: begin
            if (is_cmd) st_n = S_IDLE;
            else begin
              sec_n[7:0] = din;
              case (st_q)
                S_RSA1:  st_n = S_RSA2;
                S_ESA1:  st_n = S_ESA2;
                S_PSA1:  st_n = S_PSA2;
                default: st_n = S_WSA2;
              endcase
            end
          end
          S_RSA2, S_ESA2, S_PSA2, S_WSA2: begin
            if (is_cmd) st_n = S_IDLE;
            else begin
              sec_n[SA_W-1:8] = din[SA_HI-1:0];
              caph_n = 1'b0;
              case (st_q)
                S_RSA2:  begin st_n = S_RDATA; launch = 1'b1; end
                S_ESA2:  st_n = S_ECONF;
                S_PSA2:  st_n = S_PLOAD;
                default: st_n = S_WCONF;
              endcase
            end
          end
          S_ECONF: begin
            st_n = S_IDLE;
            if (is_cmd && din == C_ERASE_GO) launch = 1'b1;
          end
          S_PLOAD: begin
            if (is_cmd) begin
              st_n = S_IDLE;
              if (din == C_PROG_GO) begin
                launch = 1'b1; f13_n = sec_q[SA_W-1];
              end
            end else if (kind_q == K_PROG_ADD || kind_q == K_PROG_REW) begin
              ca_go = 1'b1;
            end else begin
              st_n = S_IDLE;
            end
          end
          S_WCONF: begin
            st_n = S_IDLE;
            if (is_cmd && din == C_PROG_GO && sec_q[SA_W-1] == f13_q) launch = 1'b1;
          end
          default: st_n = S_IDLE;
        endcase
      end
    end
    if (ca_go) begin
      if (!caph_q) begin
        calo_n = din; caph_n = 1'b1;
      end else begin
        caph_n = 1'b0;
        if (ca_cand <= CA_MAX) col_n = ca_cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= K_READ_MAIN; sec_q <= '0; col_q <= '0;
      calo_q <= '0; caph_q <= 1'b0; f13_q <= 1'b0;
    end else begin
      st_q <= st_n; kind_q <= kind_n; sec_q <= sec_n; col_q <= col_n;
      calo_q <= calo_n; caph_q <= caph_n; f13_q <= f13_n;
    end
  end

  always_comb begin
    case (st_q)
      S_IDLE:  mode_o = M_STANDBY;
      S_RDATA: mode_o = M_READ;
      S_ID:    mode_o = M_ID;
      S_RCVRD: mode_o = M_RECOV;
      default: mode_o = M_SETUP;
    endcase
  end

  assign launch_read = (kind_q == K_READ_MAIN) || (kind_q == K_READ_CTRL);
  assign kind_o      = kind_q;
  assign sector_o    = sec_q;
  assign column_o    = col_q;

  assert_lock_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st_q) && $stable(sec_q) && $stable(col_q));
  assert_no_launch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
  assert_col_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= CA_MAX);
  assert_recwr_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && kind_q == K_RECOV_WR) |-> sec_q[SA_W-1] == f13_q);

endmodule

// File: rtl/flash_cmd_seq_timer.sv
module flash_cmd_seq_timer #(
  parameter int unsigned OP_CYCLES  = 20,
  parameter int unsigned ACC_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic launch_read,
  input  logic op_fail,
  input  logic clr_err,
  output logic busy,
  output logic start_pulse,
  output logic err
);

  localparam int unsigned MAXC  = (OP_CYCLES > ACC_CYCLES) ? OP_CYCLES : ACC_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] OP_LOAD  = CNT_W'(OP_CYCLES - 1);
  localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_rd_q;
  logic             finish;

  assign finish = busy && (cnt_q == '0) && !launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt_q <= '0; run_rd_q <= 1'b0; start_pulse <= 1'b0; err <= 1'b0;
    end else begin
      start_pulse <= launch;
      if (launch) begin
        busy     <= 1'b1;
        cnt_q    <= launch_read ? ACC_LOAD : OP_LOAD;
        run_rd_q <= launch_read;
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else cnt_q <= cnt_q - 1'b1;
      end
      if (finish && !run_rd_q && op_fail) err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end

  assert_launch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && start_pulse);
  assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !err);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int unsigned SA_W       = 14,
  parameter int unsigned CA_W       = 12,
  parameter int unsigned OP_CYCLES  = 20,
  parameter int unsigned ACC_CYCLES = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            cmd_sel,
  input  logic            wr_stb,
  input  logic [7:0]      din,
  input  logic            op_fail,
  output logic            rb_low,
  output logic            op_start,
  output logic [2:0]      op_kind,
  output logic [SA_W-1:0] op_sector,
  output logic [CA_W-1:0] op_column,
  output logic [2:0]      mode,
  output logic            stat_err
);
  import flash_cmd_seq_pkg::*;

  logic     busy, launch, launch_read, clr_err;
  op_kind_e kind;
  mode_e    mode_e_w;

  flash_cmd_seq_fsm #(.SA_W(SA_W), .CA_W(CA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_sel(cmd_sel), .wr_stb(wr_stb),
    .din(din), .busy(busy), .launch(launch), .launch_read(launch_read),
    .clr_err(clr_err), .kind_o(kind), .sector_o(op_sector), .column_o(op_column),
    .mode_o(mode_e_w)
  );

  flash_cmd_seq_timer #(.OP_CYCLES(OP_CYCLES), .ACC_CYCLES(ACC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_read(launch_read),
    .op_fail(op_fail), .clr_err(clr_err), .busy(busy), .start_pulse(op_start),
    .err(stat_err)
  );

  assign rb_low  = busy;
  assign op_kind = kind;
  assign mode    = mode_e_w;

  assert_start_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> rb_low);

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int OPC = 20;
  localparam int ACC = 6;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b0, cmd_sel = 1'b0, wr_stb = 1'b0, op_fail = 1'b0;
  logic [7:0] din = 8'h00;
  logic rb_low, op_start, stat_err;
  logic [2:0] op_kind, mode;
  logic [13:0] op_sector;
  logic [11:0] op_column;

  int total = 0, bad = 0;
  logic [28:0] expq[$];

  always #10 clk = ~clk;

  flash_cmd_seq #(.OP_CYCLES(OPC), .ACC_CYCLES(ACC)) u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_sel(cmd_sel), .wr_stb(wr_stb),
    .din(din), .op_fail(op_fail), .rb_low(rb_low), .op_start(op_start),
    .op_kind(op_kind), .op_sector(op_sector), .op_column(op_column),
    .mode(mode), .stat_err(stat_err)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] b);
    @(negedge clk); cmd_sel = sel; din = b; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask
  task automatic cmd(logic [7:0] b); wr(1'b0, b); endtask
  task automatic adr(logic [7:0] b); wr(1'b1, b); endtask

  task automatic expect_start(logic [2:0] k, logic [13:0] s, logic [11:0] c);
    expq.push_back({k, s, c});
  endtask

  task automatic wait_ready();
    while (rb_low) @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (rb_low) begin n++; @(negedge clk); end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && op_start) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R8/R10 unexpected start actual=%0h expected=none",
                 {op_kind, op_sector, op_column});
      end else begin
        logic [28:0] e;
        e = expq.pop_front();
        if ({op_kind, op_sector, op_column} !== e) begin
          bad++;
          $display("FAIL R3/R5/R6 start actual=%0h expected=%0h",
                   {op_kind, op_sector, op_column}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R7 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rb_low", rb_low, 0);
    chk("R1 mode", mode, 0);
    chk("R1 stat_err", stat_err, 0);
    chk("R1 op_start", op_start, 0);

    // R3 serial read main area, upper bits of second byte ignored
    cmd(8'h00);
    chk("R3 setup mode", mode, 1);
    adr(8'h45);
    expect_start(3'd0, 14'h2A45, 12'h000);
    adr(8'hEA);
    count_busy(n);
    chk("R3 first access length", n, ACC);
    chk("R3 read mode", mode, 2);

    // R4 column pairs, last wins, out of range discarded
    adr(8'h34); adr(8'h02);
    chk("R4 column pair", op_column, 12'h234);
    adr(8'h50); adr(8'h09);
    chk("R4 out of range kept", op_column, 12'h234);
    adr(8'h3F); adr(8'h08);
    chk("R4 boundary 83F", op_column, 12'h83F);

    // R9 chip enable high returns to standby; R2 writes ignored while ce_n high
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    chk("R9 ce_n standby", mode, 0);
    cmd(8'h90);
    chk("R2 ce_n high write ignored", mode, 0);
    ce_n = 1'b0;

    // R3 control-area read + R7 lockout during first access
    cmd(8'hF0); adr(8'h07);
    expect_start(3'd1, 14'h0107, 12'h800);
    adr(8'h01);
    cmd(8'hFF);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); ce_n = 1'b0;
    wait_ready();
    chk("R7 read mode kept through busy", mode, 2);

    // R5 erase
    cmd(8'h20); adr(8'h10); adr(8'h03);
    expect_start(3'd2, 14'h0310, 12'h000);
    cmd(8'hB0);
    count_busy(n);
    chk("R5 erase busy length", n, OPC);
    chk("R5 mode after erase", mode, 0);

    // R6/R4 additive program with two pairs, failing (R11)
    cmd(8'h10); adr(8'h00); adr(8'h21);
    adr(8'h00); adr(8'h01); adr(8'h80); adr(8'h03);
    expect_start(3'd3, 14'h2100, 12'h380);
    op_fail = 1'b1;
    cmd(8'h40);
    wait_ready();
    op_fail = 1'b0;
    chk("R11 error set", stat_err, 1);

    // R10 recovery write: bit 13 match starts, mismatch does not
    cmd(8'h12); adr(8'h00); adr(8'h3F);
    expect_start(3'd7, 14'h3F00, 12'h000);
    cmd(8'h40);
    wait_ready();
    cmd(8'h12); adr(8'h00); adr(8'h1F); cmd(8'h40);
    @(negedge clk);
    chk("R10 mismatch no busy", rb_low, 0);
    chk("R10 mismatch standby", mode, 0);

    // R6 control program + R7 lockout of FF/50 while busy
    cmd(8'h0F); adr(8'h05); adr(8'h00);
    expect_start(3'd6, 14'h0005, 12'h800);
    cmd(8'h40);
    cmd(8'hFF); cmd(8'h50);
    wait_ready();
    chk("R7 error survives bytes while busy", stat_err, 1);
    cmd(8'h50);
    chk("R11 clear by 50H", stat_err, 0);

    // R6 full program failing, then R11 clear by FFH
    cmd(8'h1F); adr(8'h11); adr(8'h00);
    expect_start(3'd5, 14'h0011, 12'h000);
    op_fail = 1'b1;
    cmd(8'h40);
    wait_ready();
    op_fail = 1'b0;
    chk("R11 error set again", stat_err, 1);
    cmd(8'hFF);
    chk("R11 clear by FFH", stat_err, 0);

    // R6 address byte in load phase of 1FH aborts
    cmd(8'h1F); adr(8'h01); adr(8'h00); adr(8'h05);
    chk("R6 load address aborts", mode, 0);
    cmd(8'h40);
    chk("R6 no start after abort", rb_low, 0);

    // R6 rewrite program without column
    cmd(8'h11); adr(8'h22); adr(8'h33);
    expect_start(3'd4, 14'h3322, 12'h000);
    cmd(8'h40);
    wait_ready();

    // R8 unexpected command in setup
    cmd(8'h20); adr(8'h01); cmd(8'h77);
    chk("R8 unexpected cmd standby", mode, 0);
    adr(8'h02); cmd(8'hB0);
    chk("R8 no erase start", rb_low, 0);
    cmd(8'h20); adr(8'h01); adr(8'h02); cmd(8'h40);
    chk("R8 wrong confirm no start", rb_low, 0);

    // R11 identifier and recovery read modes
    cmd(8'h90);
    chk("R11 id mode", mode, 3);
    cmd(8'h01);
    chk("R11 recovery read mode", mode, 4);
    cmd(8'hFF);
    chk("R11 reset to standby", mode, 0);

    // R2 address byte in standby is not a command
    adr(8'h20);
    chk("R2 address byte not decoded", mode, 0);

    repeat (3) @(negedge clk);
    chk("R6 scoreboard drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule